// File: doc/BRIEF.md
# Debug Trigger Breakpoint Gating Unit

This block qualifies each hardware debug trigger before it may match or fire. A trigger first has to clear its own privilege-mode check and context check, which are computed elsewhere and arrive as per-trigger hit bits. A trigger whose configured action is "raise a breakpoint exception" (action code 0) is then also checked against the hart's current privilege state. This extra check stops a breakpoint from re-entering the handler that would service it.

A build-time parameter states whether the hart has supervisor mode, and it selects one of two gating schemes. With supervisor mode, the gate uses the interrupt-enable bits of the relevant status register and the breakpoint delegation bits. Without supervisor mode, the block holds a small trigger-control register with a current-enable bit and a saved-enable bit. Trap entry and machine-mode return update this register, and a CSR write port can change it. Software reads it back through a read-data output.

Top module: `trig_gate`

## Requirements
- R1: After reset, the trigger-control read value is 0. Bit 3 holds the machine trigger-enable bit (MTE), bit 7 holds the saved previous enable (MPTE), and every other bit reads 0.
- R2: A trigger whose mode-hit or context-hit input is 0 is never allowed, whatever its action.
- R3: A trigger that passes both hits and has a nonzero action is allowed in every privilege state.
- R4: With supervisor mode, a breakpoint-action trigger (action 0) is blocked in machine mode (priv 3) while the machine interrupt enable is 0, and allowed there while it is 1.
- R5: With supervisor mode, a breakpoint-action trigger is blocked in non-virtualized supervisor mode (priv 1, virt 0) when breakpoint delegation to supervisor is set and the supervisor interrupt enable is 0. Otherwise it is allowed.
- R6: With supervisor mode, a breakpoint-action trigger is blocked in virtualized supervisor mode (priv 1, virt 1) when both delegation bits are set and the virtual supervisor interrupt enable is 0. Otherwise it is allowed.
- R7: With supervisor mode, user mode (priv 0) never blocks. The trigger-control register does not exist: it reads 0, and writes, trap strobes and return strobes leave it at 0.
- R8: Without supervisor mode, a breakpoint-action trigger is blocked in machine mode exactly when MTE is 0. Supervisor-side enables and delegation bits have no effect.
- R9: Without supervisor mode, a trap strobe copies MTE into MPTE and clears MTE on the next clock edge.
- R10: Without supervisor mode, a machine-return strobe sets both MTE and MPTE to the old MPTE value.
- R11: Without supervisor mode, a CSR write loads MTE from write-data bit 3 and MPTE from bit 7. When strobes coincide, trap entry wins over return, and return wins over a write.
- R12: The allowed outputs are combinational from the current inputs and register state, and each trigger is qualified independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_i | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| virt_i | input | 1 | Virtualization flag |
| act_i | input | N_TRIG*ACT_W | Per-trigger action codes, trigger 0 in the low bits |
| mode_hit_i | input | N_TRIG | Per-trigger privilege-mode match |
| ctx_hit_i | input | N_TRIG | Per-trigger context match |
| mie_i | input | 1 | Machine interrupt enable |
| sie_i | input | 1 | Supervisor interrupt enable |
| vsie_i | input | 1 | Virtual supervisor interrupt enable |
| medeleg_bp_i | input | 1 | Breakpoint delegated from machine level |
| hedeleg_bp_i | input | 1 | Breakpoint delegated from hypervisor level |
| trap_i | input | 1 | Trap-entry strobe |
| mret_i | input | 1 | Machine-return strobe |
| tctl_we_i | input | 1 | Trigger-control write enable |
| tctl_wdata_i | input | XLEN | Trigger-control write data |
| allowed_o | output | N_TRIG | Per-trigger allowed qualifier |
| tctl_rdata_o | output | XLEN | Trigger-control read value |

## Verification
The assertions take for granted that the privilege input never carries the reserved code 2 and that the virtualization flag is 0 in machine mode. They also assume every input is held steady across each clock edge. The stimulus sets its inputs one nanosecond after a rising edge and changes only among the codes 0, 1 and 3, with virtualization raised only in supervisor mode. Strobes are released after the edge that consumes them, so each trap, return or write takes effect exactly once.

// File: rtl/trig_gate.sv
module trig_gate #(
  parameter int N_TRIG    = 2,
  parameter int ACT_W     = 4,
  parameter int XLEN      = 32,
  parameter bit HAS_SMODE = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                priv_i,
  input  logic                      virt_i,
  input  logic [N_TRIG*ACT_W-1:0]   act_i,
  input  logic [N_TRIG-1:0]         mode_hit_i,
  input  logic [N_TRIG-1:0]         ctx_hit_i,
  input  logic                      mie_i,
  input  logic                      sie_i,
  input  logic                      vsie_i,
  input  logic                      medeleg_bp_i,
  input  logic                      hedeleg_bp_i,
  input  logic                      trap_i,
  input  logic                      mret_i,
  input  logic                      tctl_we_i,
  input  logic [XLEN-1:0]           tctl_wdata_i,
  output logic [N_TRIG-1:0]         allowed_o,
  output logic [XLEN-1:0]           tctl_rdata_o
);
  localparam int          MTE_POS  = 3;
  localparam int          MPTE_POS = 7;
  localparam logic [1:0]  PRV_S    = 2'd1;
  localparam logic [1:0]  PRV_M    = 2'd3;

  logic in_m;
  logic bp_block;

  assign in_m = (priv_i == PRV_M);

  if (HAS_SMODE) begin : g_smode
    logic in_hs, in_vs;
    logic unused_tctl;
    assign in_hs = (priv_i == PRV_S) && !virt_i;
    assign in_vs = (priv_i == PRV_S) && virt_i;
    assign bp_block = (in_m  & ~mie_i)
                    | (in_hs & medeleg_bp_i & ~sie_i)
                    | (in_vs & medeleg_bp_i & hedeleg_bp_i & ~vsie_i);
    assign tctl_rdata_o = '0;
    assign unused_tctl  = ^{clk, rst_n, trap_i, mret_i, tctl_we_i, tctl_wdata_i};
  end else begin : g_tctl
    logic mte_q, mpte_q;
    logic unused_sup;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mte_q  <= 1'b0;
        mpte_q <= 1'b0;
      end else if (trap_i) begin
        mpte_q <= mte_q;
        mte_q  <= 1'b0;
      end else if (mret_i) begin
        mte_q  <= mpte_q;
      end else if (tctl_we_i) begin
        mte_q  <= tctl_wdata_i[MTE_POS];
        mpte_q <= tctl_wdata_i[MPTE_POS];
      end
    end

    assign bp_block = in_m & ~mte_q;

    always_comb begin
      tctl_rdata_o           = '0;
      tctl_rdata_o[MTE_POS]  = mte_q;
      tctl_rdata_o[MPTE_POS] = mpte_q;
    end

    assign unused_sup = ^{virt_i, mie_i, sie_i, vsie_i, medeleg_bp_i, hedeleg_bp_i, tctl_wdata_i};
  end

  for (genvar i = 0; i < N_TRIG; i++) begin : g_trig
    logic is_bp;
    assign is_bp        = (act_i[i*ACT_W +: ACT_W] == '0);
    assign allowed_o[i] = mode_hit_i[i] & ctx_hit_i[i] & ~(is_bp & bp_block);
  end

endmodule

// File: rtl/trig_gate_chk.sv
module trig_gate_chk #(
  parameter int N_TRIG    = 2,
  parameter int ACT_W     = 4,
  parameter int XLEN      = 32,
  parameter bit HAS_SMODE = 1'b0
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              priv_i,
  input logic                    virt_i,
  input logic [N_TRIG*ACT_W-1:0] act_i,
  input logic [N_TRIG-1:0]       mode_hit_i,
  input logic [N_TRIG-1:0]       ctx_hit_i,
  input logic                    mie_i,
  input logic                    sie_i,
  input logic                    vsie_i,
  input logic                    medeleg_bp_i,
  input logic                    hedeleg_bp_i,
  input logic                    trap_i,
  input logic                    mret_i,
  input logic                    tctl_we_i,
  input logic [XLEN-1:0]         tctl_wdata_i,
  input logic [N_TRIG-1:0]       allowed_o,
  input logic [XLEN-1:0]         tctl_rdata_o
);
  logic bp0;
  assign bp0 = (act_i[ACT_W-1:0] == '0);

  a_r2_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (allowed_o & ~(mode_hit_i & ctx_hit_i)) == '0);

  a_r3_other_action: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hit_i[0] && ctx_hit_i[0] && !bp0) |-> allowed_o[0]);

  if (HAS_SMODE) begin : g_s
    a_r4_m_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_i == 2'd3 && !mie_i && bp0) |-> !allowed_o[0]);
    a_r7_no_tctl: assert property (@(posedge clk) disable iff (!rst_n)
      tctl_rdata_o == '0);
  end else begin : g_n
    a_r8_m_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_i == 2'd3 && !tctl_rdata_o[3] && bp0) |-> !allowed_o[0]);
    a_r9_trap_saves: assert property (@(posedge clk) disable iff (!rst_n)
      trap_i |=> (tctl_rdata_o[7] == $past(tctl_rdata_o[3])) && !tctl_rdata_o[3]);
    a_r10_mret_restores: assert property (@(posedge clk) disable iff (!rst_n)
      (mret_i && !trap_i) |=> (tctl_rdata_o[3] == $past(tctl_rdata_o[7]))
                             && (tctl_rdata_o[7] == $past(tctl_rdata_o[7])));
  end
endmodule

bind trig_gate trig_gate_chk #(
  .N_TRIG(N_TRIG), .ACT_W(ACT_W), .XLEN(XLEN), .HAS_SMODE(HAS_SMODE)
) u_chk (.*);

// File: tb/trig_gate_bench.sv
`timescale 1ns/1ps
module trig_gate_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]  priv = '0;
  logic        virt = 1'b0;
  logic [7:0]  act = '0;
  logic [1:0]  mh = '0, ch = '0;
  logic        mie = 1'b0, sie = 1'b0, vsie = 1'b0, med = 1'b0, hed = 1'b0;
  logic        trap = 1'b0, mret = 1'b0, we = 1'b0;
  logic [31:0] wdata = '0;
  logic [1:0]  al_n, al_s;
  logic [31:0] rd_n, rd_s;

  trig_gate #(.HAS_SMODE(1'b0)) u_trig_gate (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .virt_i(virt), .act_i(act),
    .mode_hit_i(mh), .ctx_hit_i(ch), .mie_i(mie), .sie_i(sie), .vsie_i(vsie),
    .medeleg_bp_i(med), .hedeleg_bp_i(hed), .trap_i(trap), .mret_i(mret),
    .tctl_we_i(we), .tctl_wdata_i(wdata), .allowed_o(al_n), .tctl_rdata_o(rd_n));

  trig_gate #(.HAS_SMODE(1'b1)) u_trig_gate_s (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .virt_i(virt), .act_i(act),
    .mode_hit_i(mh), .ctx_hit_i(ch), .mie_i(mie), .sie_i(sie), .vsie_i(vsie),
    .medeleg_bp_i(med), .hedeleg_bp_i(hed), .trap_i(trap), .mret_i(mret),
    .tctl_we_i(we), .tctl_wdata_i(wdata), .allowed_o(al_s), .tctl_rdata_o(rd_s));

  typedef struct {
    string       tag;
    logic [1:0]  an;
    logic [1:0]  as;
    logic [31:0] rn;
  } item_t;

  item_t q[$];
  int compared = 0, mismatched = 0;
  logic m_mte = 1'b0, m_mpte = 1'b0;

  function automatic logic [1:0] exp_al(bit s);
    logic [1:0] r;
    for (int i = 0; i < 2; i++) begin
      logic pass, bp, blk;
      pass = mh[i] & ch[i];
      bp   = (act[i*4 +: 4] == 4'd0);
      if (s)
        blk = (priv == 2'd3 && !mie) ||
              (priv == 2'd1 && !virt && med && !sie) ||
              (priv == 2'd1 && virt && med && hed && !vsie);
      else
        blk = (priv == 2'd3 && !m_mte);
      r[i] = pass & !(bp & blk);
    end
    return r;
  endfunction

  task automatic step(input string tag);
    item_t it;
    @(negedge clk);
    it.tag = tag;
    it.an  = exp_al(1'b0);
    it.as  = exp_al(1'b1);
    it.rn  = (32'(m_mpte) << 7) | (32'(m_mte) << 3);
    q.push_back(it);
    @(posedge clk);
    #1;
    if (trap) begin m_mpte = m_mte; m_mte = 1'b0; end
    else if (mret) m_mte = m_mpte;
    else if (we) begin m_mte = wdata[3]; m_mpte = wdata[7]; end
    trap = 1'b0; mret = 1'b0; we = 1'b0;
  endtask

  task automatic cmp(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        cmp(it.tag, "allowed(no-S)", 32'(al_n), 32'(it.an));
        cmp(it.tag, "allowed(S)",    32'(al_s), 32'(it.as));
        cmp(it.tag, "rdata(no-S)",   rd_n, it.rn);
        cmp(it.tag, "rdata(S)",      rd_s, 32'd0);
      end
    end
  end

  bit done = 1'b0;
  initial begin : watchdog
    #100000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step("R1 reset");
    priv = 2'd0; act = 8'h22; mh = 2'b10; ch = 2'b11; step("R2 mode miss");
    mh = 2'b11; ch = 2'b01; step("R2 ctx miss");
    priv = 2'd3; ch = 2'b11; mie = 1'b0; step("R3 nonzero action in M");
    act = 8'h00; step("R4 M blocked mie0 / R8 MTE0");
    mie = 1'b1; step("R4 M allowed mie1 / R8 ignores mie");
    priv = 2'd1; virt = 1'b0; med = 1'b1; sie = 1'b0; step("R5 HS blocked / R8");
    med = 1'b0; step("R5 HS no delegation");
    med = 1'b1; sie = 1'b1; step("R5 HS sie1");
    virt = 1'b1; hed = 1'b1; vsie = 1'b0; step("R6 VS blocked");
    hed = 1'b0; step("R6 VS no hdeleg");
    hed = 1'b1; vsie = 1'b1; step("R6 VS vsie1");
    priv = 2'd0; virt = 1'b0; mie = 1'b0; sie = 1'b0; vsie = 1'b0; step("R7 user never gated");
    priv = 2'd3; we = 1'b1; wdata = 32'hFFFF_FFFF; step("R11 write all ones");
    step("R8 M allowed MTE1 / R7 write ignored");
    trap = 1'b1; step("R9 trap entry");
    step("R9 after trap MPTE only");
    mret = 1'b1; step("R10 mret");
    step("R10 after mret both set");
    we = 1'b1; wdata = 32'h0000_0080; step("R11 write MPTE only");
    trap = 1'b1; step("R9 trap with MTE0");
    step("R9 cleared");
    mret = 1'b1; step("R10 mret with MPTE0");
    we = 1'b1; wdata = 32'h0000_0008; step("R11 write MTE");
    trap = 1'b1; we = 1'b1; wdata = 32'h0000_0000; step("R11 trap beats write");
    mret = 1'b1; we = 1'b1; wdata = 32'h0000_0000; step("R11 mret beats write");
    step("R11 after mret");
    trap = 1'b1; mret = 1'b1; step("R11 trap beats mret");
    act = 8'h10; mie = 1'b0; step("R12 per-trigger mix");
    mh = 2'b01; step("R12 trigger1 miss");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule